// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the left/right frame clock for a two-channel serial audio link. It runs on the master clock `clk_m` and, in master mode, divides that clock by a small fixed set of ratios to form a bit clock. The bit clock is divided again to form the frame clock. Beside the two clocks it raises two single-cycle strobes in the master-clock domain. `bit_stb` marks the launch edge of every bit, and `frame_stb` marks the first bit of every frame. A serializer uses them to shift data without having to look at the clocks themselves.

Configuration comes in as static register-style inputs:
- a bit divide select and a frame divide select;
- bit-clock and frame-clock polarity;
- master/slave select;
- a flag that keeps the bit clock running when no transfer is active;
- a global enable.

In slave mode the block takes the bit and frame clocks from outside. It synchronizes them, passes them on, and builds the same strobes from their edges.

The control is a five-state machine:
- `ST_OFF`: disabled, or restarting after a configuration change.
- `ST_MHOLD`: master, bit clock gated.
- `ST_MRUN`: master, clocks running.
- `ST_SWAIT`: slave, waiting for a frame start.
- `ST_SRUN`: slave, locked.

Transitions:
- any state to `ST_OFF` on enable low or a configuration change;
- `ST_OFF` to `ST_MRUN` or `ST_MHOLD` on enable in master mode;
- `ST_OFF` to `ST_SWAIT` on enable in slave mode;
- `ST_MHOLD` to `ST_MRUN` when running is allowed;
- `ST_MRUN` to `ST_MHOLD` at the end of a frame when gating is allowed and no transfer is active;
- `ST_SWAIT` to `ST_SRUN` at the first detected frame start.

Top module: `aud_sclk_gen`

## Requirements
- R1: One cycle after `cfg_en` is sampled low, all of `bclk_out`, `fclk_out`, `clk_drive_en`, `bit_stb`, `frame_stb` and `right_slot` are 0. The same holds after reset.
- R2: In master mode the bit period lasts 2 `clk_m` cycles when `cfg_bdiv_sel`=0 and 4 cycles when it is 1. `bit_stb` is high for exactly the first cycle of each bit period.
- R3: In master mode a frame holds 32 bits for `cfg_fdiv_sel`=0, 64 for 1, and 128 for 2 or 3. `frame_stb` is high on the first cycle of bit 0. `right_slot` is high for the second half of the bits of each frame.
- R4: In master mode `bclk_out` equals `cfg_bpol` during the first half of each bit period and its inverse during the second half. The launch edge of the bit clock is therefore falling for `cfg_bpol`=0 and rising for 1.
- R5: While clocks are running, `fclk_out` equals `right_slot` XOR `cfg_fpol`, so the frame clock is low during the left word when `cfg_fpol`=0 and low during the right word when it is 1.
- R6: In master mode `clk_drive_en` is 1 while enabled. The first cycle after the enabling edge has both `bit_stb` and `frame_stb` high, so every start begins on the left slot.
- R7: With `cfg_nogate`=0 and `xfer_active`=0, the master clocks enter a gated state, either on enable or at the end of the current frame. In that state there are no strobes, `bclk_out`=`cfg_bpol` and `fclk_out`=`cfg_fpol`. Raising `xfer_active` (or `cfg_nogate`) restarts the clocks at a frame start in the next cycle.
- R8: A change of `cfg_master`, a divide select or a polarity bit while enabled gives one cycle with all outputs 0, after which a new frame starts. A change of `cfg_nogate` alone does not restart the counters.
- R9: After enable in slave mode there are no strobes until the first external launch edge at which the external frame clock shows the left word after having shown the right word. The external launch edge is falling on `ext_bclk` for `cfg_bpol`=0 and rising for 1. `bit_stb` rises two `clk_m` edges after the edge reaches the input and before `ext_bclk` changes again. `clk_drive_en` stays 0.
- R10: In slave mode, once locked, `bit_stb` pulses once per external bit period and `frame_stb` at every right-to-left frame change. `right_slot` is the synchronized `ext_fclk` XOR `cfg_fpol`.
- R11: `frame_stb` is never high without `bit_stb`, and never while `right_slot` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m | input | 1 | Master clock, also the logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Global enable |
| cfg_master | input | 1 | 1: generate clocks, 0: take them from outside |
| cfg_bdiv_sel | input | 1 | Bit divide: 0 = /2, 1 = /4 |
| cfg_fdiv_sel | input | 2 | Bits per frame: 0 = 32, 1 = 64, 2/3 = 128 |
| cfg_bpol | input | 1 | Bit-clock polarity (launch edge select) |
| cfg_fpol | input | 1 | Frame-clock polarity (level of the left word) |
| cfg_nogate | input | 1 | Keep the bit clock running when idle |
| xfer_active | input | 1 | A transfer is pending or in progress |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fclk | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Bit clock, generated or synchronized |
| fclk_out | output | 1 | Frame clock, generated or synchronized |
| clk_drive_en | output | 1 | Drive enable for the clock pads |
| bit_stb | output | 1 | One-cycle strobe at each bit launch |
| frame_stb | output | 1 | One-cycle strobe at each frame start |
| right_slot | output | 1 | Current bit belongs to the right word |

## Verification
On every cycle the assertions check:
- the idle outputs after disable;
- that bit strobes never come back to back;
- that the clock pads are only driven after master mode was selected;
- that a frame start always lands on a left-slot bit.

Only the directed scenarios can show the actual divide ratios and the polarity mapping, each compared cycle by cycle against the chosen ratios. The scenarios also cover:
- entry to and exit from the gated state at a frame boundary;
- the one-cycle restart after a configuration change;
- the wait in slave mode for a right-to-left frame change before any strobe appears.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_MHOLD = 3'd1,
        ST_MRUN  = 3'd2,
        ST_SWAIT = 3'd3,
        ST_SRUN  = 3'd4
    } sclk_state_e;

    // Configuration fields whose change forces a restart.
    typedef struct packed {
        logic       master;
        logic       bdiv_sel;
        logic [1:0] fdiv_sel;
        logic       bpol;
        logic       fpol;
    } sclk_cfg_t;

endpackage

// File: rtl/aud_clk_ratio.sv
module aud_clk_ratio #(
    parameter int BDIV_A = 2,
    parameter int BDIV_B = 4,
    parameter int FRM_A  = 32,
    parameter int FRM_B  = 64,
    parameter int FRM_C  = 128,
    localparam int PC_W  = $clog2(BDIV_B),
    localparam int BC_W  = $clog2(FRM_C)
) (
    input  logic            bdiv_sel,
    input  logic [1:0]      fdiv_sel,
    output logic [PC_W-1:0] pc_last,
    output logic [PC_W-1:0] pc_half,
    output logic [BC_W-1:0] bc_last,
    output logic [BC_W-1:0] bc_half
);

    localparam logic [PC_W-1:0] PC_LAST_A = PC_W'(BDIV_A - 1);
    localparam logic [PC_W-1:0] PC_LAST_B = PC_W'(BDIV_B - 1);
    localparam logic [PC_W-1:0] PC_HALF_A = PC_W'(BDIV_A / 2);
    localparam logic [PC_W-1:0] PC_HALF_B = PC_W'(BDIV_B / 2);
    localparam logic [BC_W-1:0] BC_LAST_A = BC_W'(FRM_A - 1);
    localparam logic [BC_W-1:0] BC_LAST_B = BC_W'(FRM_B - 1);
    localparam logic [BC_W-1:0] BC_LAST_C = BC_W'(FRM_C - 1);
    localparam logic [BC_W-1:0] BC_HALF_A = BC_W'(FRM_A / 2);
    localparam logic [BC_W-1:0] BC_HALF_B = BC_W'(FRM_B / 2);
    localparam logic [BC_W-1:0] BC_HALF_C = BC_W'(FRM_C / 2);

    always_comb begin
        if (bdiv_sel) begin
            pc_last = PC_LAST_B;
            pc_half = PC_HALF_B;
        end else begin
            pc_last = PC_LAST_A;
            pc_half = PC_HALF_A;
        end
    end

    always_comb begin
        unique case (fdiv_sel)
            2'd0: begin
                bc_last = BC_LAST_A;
                bc_half = BC_HALF_A;
            end
            2'd1: begin
                bc_last = BC_LAST_B;
                bc_half = BC_HALF_B;
            end
            default: begin
                bc_last = BC_LAST_C;
                bc_half = BC_HALF_C;
            end
        endcase
    end

endmodule

// File: rtl/aud_clk_divider.sv
module aud_clk_divider #(
    parameter int PC_W = 2,
    parameter int BC_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    input  logic [PC_W-1:0] pc_last,
    input  logic [BC_W-1:0] bc_last,
    output logic [PC_W-1:0] pc,
    output logic [BC_W-1:0] bc,
    output logic            bit_wrap,
    output logic            frame_end
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
            bc <= '0;
        end else if (clr) begin
            pc <= '0;
            bc <= '0;
        end else if (adv) begin
            if (pc == pc_last) begin
                pc <= '0;
                bc <= (bc == bc_last) ? '0 : bc + 1'b1;
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end

    assign bit_wrap  = (pc == pc_last);
    assign frame_end = bit_wrap && (bc == bc_last);

endmodule

// File: rtl/aud_clk_edge_sync.sv
module aud_clk_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bpol,
    input  logic fpol,
    input  logic ext_bclk,
    input  logic ext_fclk,
    output logic b_sync,
    output logic f_sync,
    output logic f_right,
    output logic launch,
    output logic fstart
);

    logic [SYNC_STAGES-1:0] b_chain;
    logic [SYNC_STAGES-1:0] f_chain;
    logic                   b_norm_d;
    logic                   seen_right;
    logic                   b_norm;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        b_chain[g] <= 1'b0;
                        f_chain[g] <= 1'b0;
                    end else begin
                        b_chain[g] <= ext_bclk;
                        f_chain[g] <= ext_fclk;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        b_chain[g] <= 1'b0;
                        f_chain[g] <= 1'b0;
                    end else begin
                        b_chain[g] <= b_chain[g-1];
                        f_chain[g] <= f_chain[g-1];
                    end
                end
            end
        end
    endgenerate

    assign b_sync  = b_chain[SYNC_STAGES-1];
    assign f_sync  = f_chain[SYNC_STAGES-1];
    assign b_norm  = b_sync ^ bpol;
    assign f_right = f_sync ^ fpol;
    assign launch  = b_norm_d && !b_norm;
    assign fstart  = launch && !f_right && seen_right;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_norm_d   <= 1'b0;
            seen_right <= 1'b0;
        end else begin
            b_norm_d <= b_norm;
            if (clr) begin
                seen_right <= 1'b0;
            end else if (launch) begin
                seen_right <= f_right;
            end else begin
                seen_right <= seen_right | f_right;
            end
        end
    end

endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen
    import aud_clk_pkg::*;
#(
    parameter int BDIV_A      = 2,
    parameter int BDIV_B      = 4,
    parameter int FRM_A       = 32,
    parameter int FRM_B       = 64,
    parameter int FRM_C       = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_m,
    input  logic       rst_n,
    input  logic       cfg_en,
    input  logic       cfg_master,
    input  logic       cfg_bdiv_sel,
    input  logic [1:0] cfg_fdiv_sel,
    input  logic       cfg_bpol,
    input  logic       cfg_fpol,
    input  logic       cfg_nogate,
    input  logic       xfer_active,
    input  logic       ext_bclk,
    input  logic       ext_fclk,
    output logic       bclk_out,
    output logic       fclk_out,
    output logic       clk_drive_en,
    output logic       bit_stb,
    output logic       frame_stb,
    output logic       right_slot
);

    localparam int PC_W = $clog2(BDIV_B);
    localparam int BC_W = $clog2(FRM_C);

    sclk_state_e     state;
    sclk_state_e     nxt;
    sclk_cfg_t       cfg_cur;
    sclk_cfg_t       cfg_q;
    logic            cfg_chg;
    logic            run_ok;

    logic [PC_W-1:0] pc_last;
    logic [PC_W-1:0] pc_half;
    logic [BC_W-1:0] bc_last;
    logic [BC_W-1:0] bc_half;
    logic [PC_W-1:0] pc;
    logic [BC_W-1:0] bc;
    logic            bit_wrap;
    logic            frame_end;

    logic            s_bclk;
    logic            s_fclk;
    logic            s_right;
    logic            s_launch;
    logic            s_fstart;

    assign cfg_cur = '{master:   cfg_master,
                       bdiv_sel: cfg_bdiv_sel,
                       fdiv_sel: cfg_fdiv_sel,
                       bpol:     cfg_bpol,
                       fpol:     cfg_fpol};
    assign cfg_chg = (cfg_cur != cfg_q);
    assign run_ok  = cfg_nogate || xfer_active;

    aud_clk_ratio #(
        .BDIV_A (BDIV_A),
        .BDIV_B (BDIV_B),
        .FRM_A  (FRM_A),
        .FRM_B  (FRM_B),
        .FRM_C  (FRM_C)
    ) u_ratio (
        .bdiv_sel (cfg_bdiv_sel),
        .fdiv_sel (cfg_fdiv_sel),
        .pc_last  (pc_last),
        .pc_half  (pc_half),
        .bc_last  (bc_last),
        .bc_half  (bc_half)
    );

    aud_clk_divider #(
        .PC_W (PC_W),
        .BC_W (BC_W)
    ) u_div (
        .clk       (clk_m),
        .rst_n     (rst_n),
        .clr       (state != ST_MRUN),
        .adv       (state == ST_MRUN),
        .pc_last   (pc_last),
        .bc_last   (bc_last),
        .pc        (pc),
        .bc        (bc),
        .bit_wrap  (bit_wrap),
        .frame_end (frame_end)
    );

    aud_clk_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk_m),
        .rst_n    (rst_n),
        .clr      (state == ST_OFF),
        .bpol     (cfg_bpol),
        .fpol     (cfg_fpol),
        .ext_bclk (ext_bclk),
        .ext_fclk (ext_fclk),
        .b_sync   (s_bclk),
        .f_sync   (s_fclk),
        .f_right  (s_right),
        .launch   (s_launch),
        .fstart   (s_fstart)
    );

    // State and configuration snapshot registers.
    always_ff @(posedge clk_m or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cfg_q <= '0;
        end else begin
            state <= nxt;
            cfg_q <= cfg_cur;
        end
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        if (!cfg_en || cfg_chg) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (cfg_master) begin
                        nxt = run_ok ? ST_MRUN : ST_MHOLD;
                    end else begin
                        nxt = ST_SWAIT;
                    end
                end
                ST_MHOLD: begin
                    if (run_ok) nxt = ST_MRUN;
                end
                ST_MRUN: begin
                    if (frame_end && !run_ok) nxt = ST_MHOLD;
                end
                ST_SWAIT: begin
                    if (s_launch && s_fstart) nxt = ST_SRUN;
                end
                ST_SRUN: begin
                    nxt = ST_SRUN;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // Output logic.
    always_comb begin
        bclk_out     = 1'b0;
        fclk_out     = 1'b0;
        clk_drive_en = 1'b0;
        bit_stb      = 1'b0;
        frame_stb    = 1'b0;
        right_slot   = 1'b0;
        unique case (state)
            ST_OFF: begin
                bclk_out = 1'b0;
            end
            ST_MHOLD: begin
                clk_drive_en = 1'b1;
                bclk_out     = cfg_bpol;
                fclk_out     = cfg_fpol;
            end
            ST_MRUN: begin
                clk_drive_en = 1'b1;
                bclk_out     = (pc >= pc_half) ^ cfg_bpol;
                right_slot   = (bc >= bc_half);
                fclk_out     = (bc >= bc_half) ^ cfg_fpol;
                bit_stb      = (pc == '0);
                frame_stb    = (pc == '0) && (bc == '0);
            end
            ST_SWAIT: begin
                bclk_out   = s_bclk;
                fclk_out   = s_fclk;
                right_slot = s_right;
                bit_stb    = s_launch && s_fstart;
                frame_stb  = s_launch && s_fstart;
            end
            ST_SRUN: begin
                bclk_out   = s_bclk;
                fclk_out   = s_fclk;
                right_slot = s_right;
                bit_stb    = s_launch;
                frame_stb  = s_fstart;
            end
            default: begin
                bclk_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/aud_sclk_gen_chk.sv
module aud_sclk_gen_chk (
    input logic clk_m,
    input logic rst_n,
    input logic cfg_en,
    input logic cfg_master,
    input logic bclk_out,
    input logic fclk_out,
    input logic clk_drive_en,
    input logic bit_stb,
    input logic frame_stb,
    input logic right_slot
);

    // R1
    idle_when_off_chk: assert property (@(posedge clk_m) disable iff (!rst_n)
        !cfg_en |=> (!bclk_out && !fclk_out && !clk_drive_en &&
                     !bit_stb && !frame_stb && !right_slot));

    // R2
    no_back_to_back_bit_chk: assert property (@(posedge clk_m) disable iff (!rst_n)
        bit_stb |=> !bit_stb);

    // R6
    drive_only_master_chk: assert property (@(posedge clk_m) disable iff (!rst_n)
        clk_drive_en |-> $past(cfg_master));

    // R11
    frame_with_bit_chk: assert property (@(posedge clk_m) disable iff (!rst_n)
        frame_stb |-> bit_stb);

    // R11
    frame_on_left_chk: assert property (@(posedge clk_m) disable iff (!rst_n)
        frame_stb |-> !right_slot);

endmodule

bind aud_sclk_gen aud_sclk_gen_chk u_chk (
    .clk_m        (clk_m),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .cfg_master   (cfg_master),
    .bclk_out     (bclk_out),
    .fclk_out     (fclk_out),
    .clk_drive_en (clk_drive_en),
    .bit_stb      (bit_stb),
    .frame_stb    (frame_stb),
    .right_slot   (right_slot)
);

// File: tb/aud_sclk_gen_bench.sv
`timescale 1ns/1ps
module aud_sclk_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk_m = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_master = 1'b0;
    logic       cfg_bdiv_sel = 1'b0;
    logic [1:0] cfg_fdiv_sel = 2'd0;
    logic       cfg_bpol = 1'b0;
    logic       cfg_fpol = 1'b0;
    logic       cfg_nogate = 1'b1;
    logic       xfer_active = 1'b0;
    logic       ext_bclk = 1'b0;
    logic       ext_fclk = 1'b0;
    logic       bclk_out, fclk_out, clk_drive_en, bit_stb, frame_stb, right_slot;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk_m = ~clk_m;

    aud_sclk_gen u_aud_sclk_gen (
        .clk_m        (clk_m),
        .rst_n        (rst_n),
        .cfg_en       (cfg_en),
        .cfg_master   (cfg_master),
        .cfg_bdiv_sel (cfg_bdiv_sel),
        .cfg_fdiv_sel (cfg_fdiv_sel),
        .cfg_bpol     (cfg_bpol),
        .cfg_fpol     (cfg_fpol),
        .cfg_nogate   (cfg_nogate),
        .xfer_active  (xfer_active),
        .ext_bclk     (ext_bclk),
        .ext_fclk     (ext_fclk),
        .bclk_out     (bclk_out),
        .fclk_out     (fclk_out),
        .clk_drive_en (clk_drive_en),
        .bit_stb      (bit_stb),
        .frame_stb    (frame_stb),
        .right_slot   (right_slot)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_m);
        #1;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_m);
    endtask

    function automatic int outs_word();
        return {26'd0, bclk_out, fclk_out, clk_drive_en, bit_stb, frame_stb, right_slot};
    endfunction

    task automatic t_reset();
        #1;
        check("R1 outputs in reset", outs_word(), 0);
        wait_neg(3);
        rst_n = 1'b1;
        step();
        check("R1 outputs after reset", outs_word(), 0);
    endtask

    // R2 R3 R4 R5 R6: free-running master, compared against the ratios every cycle
    task automatic t_master(input logic bs, input logic [1:0] fs, input logic bp, input logic fp);
        int d, r, e_bit, e_frm, e_bclk, e_fclk, e_slot, e_drv;
        d = bs ? 4 : 2;
        r = (fs == 2'd0) ? 32 : (fs == 2'd1) ? 64 : 128;
        e_bit = 0; e_frm = 0; e_bclk = 0; e_fclk = 0; e_slot = 0; e_drv = 0;
        @(negedge clk_m);
        cfg_en = 1'b0; cfg_master = 1'b1; cfg_bdiv_sel = bs; cfg_fdiv_sel = fs;
        cfg_bpol = bp; cfg_fpol = fp; cfg_nogate = 1'b1; xfer_active = 1'b0;
        wait_neg(3);
        cfg_en = 1'b1;
        for (int k = 0; k < 2 * r * d; k++) begin
            int p, b;
            logic slot;
            step();
            p = k % d;
            b = (k / d) % r;
            slot = (b >= r / 2);
            if (bit_stb != (p == 0)) e_bit++;
            if (frame_stb != (p == 0 && b == 0)) e_frm++;
            if (bclk_out != ((p >= d / 2) ^ bp)) e_bclk++;
            if (right_slot != slot) e_slot++;
            if (fclk_out != (slot ^ fp)) e_fclk++;
            if (!clk_drive_en) e_drv++;
        end
        check("R2 bit strobe cadence", e_bit, 0);
        check("R3 frame strobe cadence", e_frm, 0);
        check("R3 right slot half", e_slot, 0);
        check("R4 bit clock polarity", e_bclk, 0);
        check("R5 frame clock polarity", e_fclk, 0);
        check("R6 drive enable", e_drv, 0);
        @(negedge clk_m);
        cfg_en = 1'b0;
        step();
        check("R1 idle after disable", outs_word(), 0);
    endtask

    // R7: gated master clock
    task automatic t_gating();
        int stb, bad;
        @(negedge clk_m);
        cfg_en = 1'b0; cfg_master = 1'b1; cfg_bdiv_sel = 1'b0; cfg_fdiv_sel = 2'd0;
        cfg_bpol = 1'b1; cfg_fpol = 1'b0; cfg_nogate = 1'b0; xfer_active = 1'b0;
        wait_neg(3);
        cfg_en = 1'b1;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            step();
            if (bit_stb || frame_stb || bclk_out != 1'b1 || fclk_out != 1'b0 || !clk_drive_en) bad++;
        end
        check("R7 held while idle", bad, 0);
        @(negedge clk_m);
        xfer_active = 1'b1;
        step();
        check("R7 restart at frame start", {bit_stb, frame_stb, right_slot}, 3'b110);
        @(negedge clk_m);
        xfer_active = 1'b0;
        stb = 1;
        for (int k = 1; k < 32 * 2; k++) begin
            @(posedge clk_m); #1;
            if (bit_stb) stb++;
        end
        check("R7 frame completes before gating", stb, 32);
        stb = 0;
        for (int k = 0; k < 6; k++) begin
            step();
            if (bit_stb || bclk_out != 1'b1) stb++;
        end
        check("R7 gated at frame end", stb, 0);
        @(negedge clk_m);
        cfg_en = 1'b0;
        cfg_nogate = 1'b1;
    endtask

    // R8: restart on configuration change, nogate change ignored
    task automatic t_cfg_change();
        @(negedge clk_m);
        cfg_en = 1'b0; cfg_master = 1'b1; cfg_bdiv_sel = 1'b0; cfg_fdiv_sel = 2'd0;
        cfg_bpol = 1'b0; cfg_fpol = 1'b0; cfg_nogate = 1'b1; xfer_active = 1'b1;
        wait_neg(3);
        cfg_en = 1'b1;
        for (int k = 0; k < 11; k++) step();
        check("R8 mid-frame strobe", {bit_stb, frame_stb}, 2'b10);
        @(negedge clk_m);
        cfg_nogate = 1'b0;
        step();
        check("R8 nogate change no strobe", {bit_stb, clk_drive_en}, 2'b01);
        step();
        check("R8 nogate change keeps cadence", {bit_stb, frame_stb}, 2'b10);
        @(negedge clk_m);
        cfg_fpol = 1'b1;
        step();
        check("R8 restart cycle idle", outs_word(), 0);
        step();
        check("R8 new frame after change", {bit_stb, frame_stb, fclk_out, right_slot}, 4'b1110);
        @(negedge clk_m);
        cfg_en = 1'b0; cfg_nogate = 1'b1; xfer_active = 1'b0;
        step();
        check("R1 idle after restart test", outs_word(), 0);
    endtask

    // R9 R10: slave mode with bench-driven external clocks, 16 bits per frame
    task automatic t_slave(input logic bp, input logic fp);
        localparam int H = 4;
        localparam int BITS = 16;
        int nbit, nfrm, e_lvl, e_slot, e_drv, e_gap, since, early;
        @(negedge clk_m);
        cfg_en = 1'b0; cfg_master = 1'b0; cfg_bpol = bp; cfg_fpol = fp;
        ext_bclk = 1'b1 ^ bp;
        ext_fclk = 1'b1 ^ fp;
        wait_neg(4);
        cfg_en = 1'b1;
        early = 0;
        for (int k = 0; k < 12; k++) begin
            step();
            if (bit_stb || frame_stb) early++;
        end
        check("R9 no strobe before frame start", early, 0);
        nbit = 0; nfrm = 0; e_lvl = 0; e_slot = 0; e_drv = 0; e_gap = 0; since = 0;
        for (int k = 0; k < 3 * BITS * 2 * H; k++) begin
            int j;
            logic nb, fr;
            @(negedge clk_m);
            nb = ((k / H) % 2) != 0;
            j = k / (2 * H);
            fr = (j % BITS) >= (BITS / 2);
            ext_bclk = nb ^ bp;
            ext_fclk = fr ^ fp;
            step();
            if (clk_drive_en) e_drv++;
            if (bit_stb) begin
                nbit++;
                since++;
                if ((ext_bclk ^ bp) != 1'b0) e_lvl++;
            end
            if (frame_stb) begin
                if (right_slot) e_slot++;
                if (nfrm > 0 && since != BITS + 1) e_gap++;
                nfrm++;
                since = 1;
            end
        end
        check("R9 strobe on launch edge level", e_lvl, 0);
        check("R9 no clock drive in slave", e_drv, 0);
        check("R10 bit strobe count", nbit, 3 * BITS);
        check("R10 frame strobe count", nfrm, 3);
        check("R10 bits per frame", e_gap, 0);
        check("R10 frame start on left", e_slot, 0);
        @(negedge clk_m);
        cfg_en = 1'b0;
        step();
        check("R1 idle after slave", outs_word(), 0);
    endtask

    initial begin
        t_reset();
        t_master(1'b0, 2'd0, 1'b0, 1'b0);
        t_master(1'b1, 2'd1, 1'b1, 1'b1);
        t_master(1'b0, 2'd2, 1'b1, 1'b0);
        t_master(1'b1, 2'd3, 1'b0, 1'b1);
        t_gating();
        t_cfg_change();
        t_slave(1'b0, 1'b0);
        t_slave(1'b1, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule